// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Condition Flags

This block is the combinational arithmetic and logic stage of a small accumulator-based processor. Each operation takes three inputs: the accumulator, one 8-bit operand and the stored carry flag. A 3-bit operation code selects the function. This code is bits 5:3 of the instruction, so the decoder passes those bits through unchanged. The block returns the 8-bit result and a complete condition flag byte, which the surrounding core writes back to the accumulator and the flag register.

Eight functions are supported: add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. Flag meaning depends on the operation. The shared parity/overflow flag reports signed overflow after arithmetic and even parity after logic. Half-carry is forced high by AND and forced low by OR and XOR. The N flag records whether the last operation was a subtraction, so that a later decimal adjust can use it.

Top module: `alu8_core`

## Requirements
- R1: The operation code selects the function as follows: 000 add, 001 add with carry, 010 subtract, 011 subtract with borrow, 100 AND, 101 XOR, 110 OR, 111 compare.
- R2: Subtract with borrow returns (A − operand − carry_in) mod 256. Plain subtract returns (A − operand) mod 256 and ignores carry_in.
- R3: The flag byte carries S in bit 7, Z in bit 6, H in bit 4, P/V in bit 2, N in bit 1 and C in bit 0. Bits 5 and 3 are always 0.
- R4: For every operation, S equals bit 7 of the computed value and Z is 1 exactly when the computed value is 0x00.
- R5: For subtract, subtract with borrow and compare, C is 1 when the full subtraction borrows and H is 1 when the low nibble borrows from bit 4.
- R6: For subtract, subtract with borrow and compare, N is 1 and P/V is 1 when the signed two's-complement difference falls outside −128..127.
- R7: For AND, the result is A & operand, H is 1, N is 0, C is 0, and P/V is 1 when the result has an even number of ones.
- R8: For OR and XOR, the result is the bitwise OR or XOR, H, N and C are 0, and P/V is 1 on even parity of the result.
- R9: For add and add with carry, the result is (A + operand [+ carry_in]) mod 256, C is the carry out of bit 7, H is the carry out of bit 3, P/V is signed overflow and N is 0. Plain add ignores carry_in.
- R10: Compare returns the accumulator unchanged on the result port and sets the flags exactly as plain subtract would.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| carry_i | input | 1 | Stored carry flag |
| op_sel_i | input | 3 | Operation code |
| result_o | output | 8 | Computed result |
| flags_o | output | 8 | Condition flag byte |

## Verification
Signed overflow on subtraction is the hardest corner to reach from the ports. It needs operands of opposite sign whose difference lands with the wrong sign, and random stimulus lands there only now and then. A half-borrow that does not come with a full borrow is similarly narrow. The stimulus therefore crosses the boundary values 0x00, 0x7F, 0x80 and 0xFF pairwise, over all eight operations and both carry_in values. Directed cases such as 0x80 − 0x01 and 0x10 − 0x01 pin each of these flags individually before the random sweep runs.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_ADC = 3'b001,
    OP_SUB = 3'b010,
    OP_SBC = 3'b011,
    OP_AND = 3'b100,
    OP_XOR = 3'b101,
    OP_OR  = 3'b110,
    OP_CMP = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_XOR = 2'd1,
    LF_OR  = 2'd2
  } logic_fn_e;

  localparam int FLG_S  = 7;
  localparam int FLG_Z  = 6;
  localparam int FLG_H  = 4;
  localparam int FLG_PV = 2;
  localparam int FLG_N  = 1;
  localparam int FLG_C  = 0;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o,
  output logic         hc_o,
  output logic         ov_o
);
  localparam int HALF = W / 2;
  localparam int UPW  = W - HALF;

  logic [W-1:0]  bx;
  logic          ci;
  logic [HALF:0] lo;
  logic [UPW:0]  hi;

  // Subtraction is done as a + ~b + ~borrow; carries are inverted back to borrows.
  always_comb begin
    bx    = b_i ^ {W{sub_i}};
    ci    = cin_i ^ sub_i;
    lo    = {1'b0, a_i[HALF-1:0]} + {1'b0, bx[HALF-1:0]} + {{HALF{1'b0}}, ci};
    hi    = {1'b0, a_i[W-1:HALF]} + {1'b0, bx[W-1:HALF]} + {{UPW{1'b0}}, lo[HALF]};
    sum_o = {hi[UPW-1:0], lo[HALF-1:0]};
    cy_o  = hi[UPW] ^ sub_i;
    hc_o  = lo[HALF] ^ sub_i;
    ov_o  = (a_i[W-1] == bx[W-1]) && (sum_o[W-1] != a_i[W-1]);
  end

  logic [W+1:0] lhs;
  logic [W+1:0] rhs;

  always_comb begin
    if (sub_i) begin
      lhs = {2'b00, a_i} + {1'b0, cy_o, {W{1'b0}}};
      rhs = {2'b00, sum_o} + {2'b00, b_i} + {{(W+1){1'b0}}, cin_i};
    end else begin
      lhs = {1'b0, cy_o, sum_o};
      rhs = {2'b00, a_i} + {2'b00, b_i} + {{(W+1){1'b0}}, cin_i};
    end
    AST_SUM_BALANCE: assert (lhs == rhs) else $error("sum/borrow inconsistent"); // R9
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_fn_e    fn_i,
  output logic [W-1:0] res_o,
  output logic         even_o
);

  always_comb begin
    unique case (fn_i)
      LF_AND:  res_o = a_i & b_i;
      LF_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i | b_i;
    endcase
    even_o = ~(^res_o);
  end

  always_comb begin
    AST_EVEN_PARITY: assert (even_o == ($countones(res_o) % 2 == 0)) else $error("parity"); // R7
    if (fn_i == LF_AND)
      AST_AND_SUBSET: assert ((res_o & ~(a_i & b_i)) == '0) else $error("and bits"); // R7
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic       carry_i,
  input  logic [2:0] op_sel_i,
  output logic [7:0] result_o,
  output logic [7:0] flags_o
);
  localparam int W = 8;

  alu_op_e   op;
  logic      is_sub;
  logic      is_logic;
  logic      use_cin;
  logic_fn_e lfn;

  always_comb begin
    op       = alu_op_e'(op_sel_i);
    is_sub   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    is_logic = (op == OP_AND) || (op == OP_XOR) || (op == OP_OR);
    use_cin  = (op == OP_ADC) || (op == OP_SBC);
    unique case (op)
      OP_AND:  lfn = LF_AND;
      OP_XOR:  lfn = LF_XOR;
      default: lfn = LF_OR;
    endcase
  end

  logic [W-1:0] ar_sum;
  logic         ar_cy;
  logic         ar_hc;
  logic         ar_ov;

  alu8_addsub #(.W(W)) u_arith (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .sub_i (is_sub),
    .cin_i (use_cin & carry_i),
    .sum_o (ar_sum),
    .cy_o  (ar_cy),
    .hc_o  (ar_hc),
    .ov_o  (ar_ov)
  );

  logic [W-1:0] lg_res;
  logic         lg_even;

  alu8_logic #(.W(W)) u_logic (
    .a_i    (acc_i),
    .b_i    (opnd_i),
    .fn_i   (lfn),
    .res_o  (lg_res),
    .even_o (lg_even)
  );

  logic [W-1:0] value;

  always_comb begin
    value    = is_logic ? lg_res : ar_sum;
    result_o = (op == OP_CMP) ? acc_i : value;
    flags_o          = '0;
    flags_o[FLG_S]   = value[W-1];
    flags_o[FLG_Z]   = (value == '0);
    flags_o[FLG_H]   = is_logic ? (op == OP_AND) : ar_hc;
    flags_o[FLG_PV]  = is_logic ? lg_even : ar_ov;
    flags_o[FLG_N]   = is_sub;
    flags_o[FLG_C]   = is_logic ? 1'b0 : ar_cy;
  end

  always_comb begin
    AST_SPARE_ZERO: assert (flags_o[5] == 1'b0 && flags_o[3] == 1'b0) else $error("spare bits"); // R3
    if (op == OP_CMP)
      AST_CMP_KEEP: assert (result_o == acc_i) else $error("compare changed result"); // R10
    if (is_logic)
      AST_LOGIC_CLEAR: assert (!flags_o[FLG_C] && !flags_o[FLG_N]) else $error("logic C/N"); // R8
    if (is_sub)
      AST_SUB_MARK: assert (flags_o[FLG_N]) else $error("N missing"); // R6
  end

endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] acc, opnd, res, flg;
  logic       cin;
  logic [2:0] op;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  alu8_core u0 (
    .acc_i    (acc),
    .opnd_i   (opnd),
    .carry_i  (cin),
    .op_sel_i (op),
    .result_o (res),
    .flags_o  (flg)
  );

  function automatic bit even_par(input logic [7:0] v);
    return ($countones(v) % 2) == 0;
  endfunction

  // Reference: returns {result, flags}
  function automatic logic [15:0] model(input logic [2:0] o, input logic [7:0] a,
                                        input logic [7:0] b, input logic c);
    int ua, ub, sa, sb, ci, full, nib, sgn;
    logic [7:0] v, r, f;
    ua = int'(a); ub = int'(b);
    sa = (ua > 127) ? ua - 256 : ua;
    sb = (ub > 127) ? ub - 256 : ub;
    ci = (o == 3'b001 || o == 3'b011) ? int'(c) : 0;
    f = 8'h00;
    case (o)
      3'b000, 3'b001: begin
        full = ua + ub + ci; nib = (ua % 16) + (ub % 16) + ci; sgn = sa + sb + ci;
        v = full[7:0];
        f[0] = full > 255; f[4] = nib > 15; f[2] = (sgn > 127) || (sgn < -128);
      end
      3'b010, 3'b011, 3'b111: begin
        full = ua - ub - ci; nib = (ua % 16) - (ub % 16) - ci; sgn = sa - sb - ci;
        v = full[7:0];
        f[0] = full < 0; f[4] = nib < 0; f[2] = (sgn > 127) || (sgn < -128); f[1] = 1'b1;
      end
      3'b100: begin v = a & b; f[4] = 1'b1; f[2] = even_par(v); end
      3'b101: begin v = a ^ b; f[2] = even_par(v); end
      default: begin v = a | b; f[2] = even_par(v); end
    endcase
    f[7] = v[7];
    f[6] = (v == 8'h00);
    r = (o == 3'b111) ? a : v;
    return {r, f};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h cin=%0b: actual %02h expected %02h",
               tag, op, acc, opnd, cin, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic c);
    @(negedge clk);
    op = o; acc = a; opnd = b; cin = c;
    #1;
  endtask

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'b000, 3'b001: return "R9";
      3'b010, 3'b011: return "R2";
      3'b100:         return "R7";
      3'b101, 3'b110: return "R8";
      default:        return "R10";
    endcase
  endfunction

  task automatic check_vector(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
                              input logic c);
    logic [15:0] e;
    apply(o, a, b, c);
    e = model(o, a, b, c);
    chk(op_tag(o), res, e[15:8]);
    chk("R4", flg & 8'hC0, e[7:0] & 8'hC0);
    chk("R3", flg & 8'h28, 8'h00);
    if (o == 3'b010 || o == 3'b011 || o == 3'b111) begin
      chk("R5", flg & 8'h11, e[7:0] & 8'h11);
      chk("R6", flg & 8'h06, e[7:0] & 8'h06);
    end else begin
      chk(op_tag(o), flg, e[7:0]);
    end
  endtask

  task automatic test_idle;
    apply(3'b000, 8'h00, 8'h00, 1'b0);
    chk("R4", flg, 8'h40);
    chk("R9", res, 8'h00);
  endtask

  task automatic test_opcode_map;
    logic [7:0] exp_r [8];
    exp_r = '{8'h4B, 8'h4C, 8'h2D, 8'h2C, 8'h0C, 8'h33, 8'h3F, 8'h3C};
    for (int i = 0; i < 8; i++) begin
      apply(3'(i), 8'h3C, 8'h0F, 1'b1);
      chk("R1", res, exp_r[i]);
    end
  endtask

  task automatic test_sub_corners;
    apply(3'b010, 8'h80, 8'h01, 1'b0);   // signed overflow, no borrow
    chk("R6", flg, 8'h16);               // H set, V set, N set
    chk("R2", res, 8'h7F);
    apply(3'b010, 8'h10, 8'h01, 1'b1);   // half-borrow only, carry ignored
    chk("R5", flg, 8'h12);
    chk("R2", res, 8'h0F);
    apply(3'b011, 8'h00, 8'h00, 1'b1);   // full borrow through zero
    chk("R5", flg, 8'h93);
    chk("R2", res, 8'hFF);
    apply(3'b111, 8'h05, 8'h05, 1'b1);   // compare equal
    chk("R10", res, 8'h05);
    chk("R10", flg, 8'h42);
  endtask

  task automatic test_logic_flags;
    apply(3'b100, 8'hF0, 8'h0F, 1'b1);
    chk("R7", flg, 8'h54);               // Z, H, even parity
    apply(3'b110, 8'h01, 8'h02, 1'b1);
    chk("R8", flg, 8'h04);
    apply(3'b101, 8'hFF, 8'h7F, 1'b1);
    chk("R8", flg, 8'h80);               // 0x80: odd parity, S set
  endtask

  task automatic test_add_corners;
    apply(3'b000, 8'h7F, 8'h01, 1'b1);   // carry ignored, overflow
    chk("R9", res, 8'h80);
    chk("R9", flg, 8'h94);
    apply(3'b001, 8'hFF, 8'h00, 1'b1);
    chk("R9", flg, 8'h51);
  endtask

  task automatic test_boundaries;
    logic [7:0] bv [4];
    bv = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int c = 0; c < 2; c++)
            check_vector(3'(o), bv[i], bv[j], 1'(c));
  endtask

  task automatic test_random;
    for (int k = 0; k < 1500; k++)
      check_vector(3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom), 1'($urandom));
  endtask

  initial begin
    int cyc;
    for (cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    op = 3'b000; acc = 8'h00; opnd = 8'h00; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    test_idle();
    test_opcode_map();
    test_sub_corners();
    test_logic_flags();
    test_add_corners();
    test_boundaries();
    test_random();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule